// File: doc/BRIEF.md
# Prescaled Auto-Reload Wake-Up Timer

This block is a long-period down counter meant to keep running while the rest of a chip sleeps. A 7-bit prescaler sits under a 16-bit loadable counter. Together they form one 23-bit value that falls by one on each selected clock tick. When a tick arrives while the whole value is zero, the counter refills itself from a reload register and sets a sticky event flag. The flag, gated by an enable bit, drives one output that serves both as an interrupt request and as a wake-up request from power-down.

The counting clock is given as a per-cycle enable on the single block clock. Either the CPU clock tick or the crystal oscillator tick can be selected. When the crystal already serves as the CPU clock, the selector ignores the crystal choice and uses the CPU tick. Software-facing strobes write the reload value, write the control fields (run, source and interrupt enable together) and clear the flag.

The control logic is a two-state machine. ST_HALT means the counter is frozen and a reload write also loads the counter. ST_RUN means the counter decrements on ticks. Transition GO (ST_HALT to ST_RUN) is a control write with run set. Transition STOP (ST_RUN to ST_HALT) is a control write with run clear. Only the power-on reset input initializes the block, so resets from any other source leave its state untouched.

Top module: `rtc_wake_timer`

## Requirements
- R1: While in ST_RUN, each selected tick lowers the 23-bit value {rtc_count, rtc_presc} by exactly one. The prescaler (low 7 bits) wraps from 0 to 127 and borrows one from rtc_count.
- R2: A reload_wr in ST_HALT stores reload_din and, on the same clock edge, sets rtc_count to reload_din and rtc_presc to 127. A reload_wr in ST_RUN changes only the stored reload value and leaves the current count unchanged.
- R3: In ST_HALT, ticks leave the value unchanged and rtc_running is 0. A control write with ctrl_run=1 moves to ST_RUN (rtc_running=1 after that edge), and counting starts with the first tick in a later cycle.
- R4: A selected tick in ST_RUN while the value is zero reloads {stored reload, 127} and sets rtc_flag. A reload value R therefore gives a flag every (R+1)*128 ticks.
- R5: With the source bit ctrl_xsel=1 the crystal tick xtal_tick is counted, and with ctrl_xsel=0 the CPU tick cclk_tick is counted. When xtal_is_cpu=1, cclk_tick is counted whatever ctrl_xsel holds.
- R6: rtc_flag stays set until a flag_clr strobe. If a reload event and flag_clr fall in the same cycle, the flag ends set.
- R7: rtc_irq equals rtc_flag AND the stored interrupt enable.
- R8: por_n low (asynchronous) gives ST_HALT, source 0, interrupt enable 0, flag 0, stored reload 0, rtc_count 0 and rtc_presc 127. No other input resets anything.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| cclk_tick | input | 1 | CPU clock tick enable |
| xtal_tick | input | 1 | Crystal oscillator tick enable |
| xtal_is_cpu | input | 1 | High when the crystal is the CPU clock |
| reload_wr | input | 1 | Reload register write strobe |
| reload_din | input | 16 | Reload value to write |
| ctrl_wr | input | 1 | Control write strobe |
| ctrl_run | input | 1 | Run bit written by ctrl_wr |
| ctrl_xsel | input | 1 | Source bit written by ctrl_wr (1 = crystal) |
| ctrl_irq_en | input | 1 | Interrupt/wake enable written by ctrl_wr |
| flag_clr | input | 1 | Clears the event flag |
| rtc_count | output | 16 | Current 16-bit counter |
| rtc_presc | output | 7 | Current prescaler |
| rtc_flag | output | 1 | Sticky event flag |
| rtc_irq | output | 1 | Interrupt / wake-up request |
| rtc_running | output | 1 | High in ST_RUN |

## Verification
On every cycle, the assertions check the step-by-one decrement, that the value stays frozen in ST_HALT, that the refill from the stored reload value happens at zero, that the flag rises only at a wrap, that the flag holds until cleared, and that the CPU tick is used when the crystal is the CPU clock. Several behaviours only the bench scenarios can show. These are the full wrap period for each small reload value, the split between a halted and a running reload write, set winning over a same-cycle clear, the gating of the request output, and the default values after a power-on reset in mid-run.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    localparam int RTC_PRE_W = 7;
    localparam int RTC_CNT_W = 16;

    typedef enum logic {
        ST_HALT = 1'b0,
        ST_RUN  = 1'b1
    } rtc_state_e;
endpackage

// File: rtl/rtc_tick_sel.sv
module rtc_tick_sel (
    input  logic cclk_tick,
    input  logic xtal_tick,
    input  logic xtal_is_cpu,
    input  logic sel_xtal,
    output logic tick
);
    logic use_xtal;

    // the crystal cannot feed the timer while it is also the CPU clock
    assign use_xtal = sel_xtal && !xtal_is_cpu;
    assign tick     = use_xtal ? xtal_tick : cclk_tick;

    always_comb begin
        if (xtal_is_cpu) begin
            AST_CPU_FORCED: assert (tick == cclk_tick); // R5
        end
    end
endmodule

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         por_n,
    input  logic         load,
    input  logic         step,
    output logic [W-1:0] value,
    output logic         zero
);
    logic [W-1:0] q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)
            q <= '1;
        else if (load)
            q <= '1;
        else if (step)
            q <= q - W'(1);
    end

    assign value = q;
    assign zero  = (q == '0);
endmodule

// File: rtl/rtc_main_count.sv
module rtc_main_count #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         por_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         step,
    output logic [W-1:0] value,
    output logic         zero
);
    logic [W-1:0] q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)
            q <= '0;
        else if (load)
            q <= load_val;
        else if (step)
            q <= q - W'(1);
    end

    assign value = q;
    assign zero  = (q == '0);
endmodule

// File: rtl/rtc_wake_timer.sv
module rtc_wake_timer
    import rtc_pkg::*;
#(
    parameter int PRE_W = RTC_PRE_W,
    parameter int CNT_W = RTC_CNT_W
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             cclk_tick,
    input  logic             xtal_tick,
    input  logic             xtal_is_cpu,
    input  logic             reload_wr,
    input  logic [CNT_W-1:0] reload_din,
    input  logic             ctrl_wr,
    input  logic             ctrl_run,
    input  logic             ctrl_xsel,
    input  logic             ctrl_irq_en,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] rtc_count,
    output logic [PRE_W-1:0] rtc_presc,
    output logic             rtc_flag,
    output logic             rtc_irq,
    output logic             rtc_running
);
    localparam int TOT_W = PRE_W + CNT_W;

    rtc_state_e       state_q, state_d;
    logic [CNT_W-1:0] reload_q;
    logic             xsel_q, ie_q, flag_q;
    logic             tick;
    logic             counting, halted_load, wrap;
    logic             pre_zero, cnt_zero, pre_load, pre_step, cnt_step;
    logic [CNT_W-1:0] cnt_val;
    logic [TOT_W-1:0] full_value;

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)
            state_q <= ST_HALT;
        else
            state_q <= state_d;
    end

    // ---------------- transitions GO / STOP ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT: if (ctrl_wr && ctrl_run)  state_d = ST_RUN;   // GO
            ST_RUN:  if (ctrl_wr && !ctrl_run) state_d = ST_HALT;  // STOP
            default: state_d = ST_HALT;
        endcase
    end

    // ---------------- state-driven outputs ----------------
    always_comb begin
        counting    = 1'b0;
        halted_load = 1'b0;
        unique case (state_q)
            ST_HALT: halted_load = reload_wr;
            ST_RUN:  counting    = 1'b1;
            default: ;
        endcase
    end
    assign rtc_running = counting;

    // ---------------- configuration and flag ----------------
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            reload_q <= '0;
            xsel_q   <= 1'b0;
            ie_q     <= 1'b0;
            flag_q   <= 1'b0;
        end else begin
            if (reload_wr)
                reload_q <= reload_din;
            if (ctrl_wr) begin
                xsel_q <= ctrl_xsel;
                ie_q   <= ctrl_irq_en;
            end
            if (wrap)
                flag_q <= 1'b1;
            else if (flag_clr)
                flag_q <= 1'b0;
        end
    end

    // ---------------- counting datapath ----------------
    rtc_tick_sel u_sel (
        .cclk_tick   (cclk_tick),
        .xtal_tick   (xtal_tick),
        .xtal_is_cpu (xtal_is_cpu),
        .sel_xtal    (xsel_q),
        .tick        (tick)
    );

    assign wrap     = counting && tick && pre_zero && cnt_zero;
    assign pre_load = halted_load || wrap;
    assign pre_step = counting && tick && !wrap;
    assign cnt_step = counting && tick && pre_zero && !cnt_zero;
    assign cnt_val  = halted_load ? reload_din : reload_q;

    rtc_prescaler #(.W(PRE_W)) u_pre (
        .clk   (clk),
        .por_n (por_n),
        .load  (pre_load),
        .step  (pre_step),
        .value (rtc_presc),
        .zero  (pre_zero)
    );

    rtc_main_count #(.W(CNT_W)) u_cnt (
        .clk      (clk),
        .por_n    (por_n),
        .load     (pre_load),
        .load_val (cnt_val),
        .step     (cnt_step),
        .value    (rtc_count),
        .zero     (cnt_zero)
    );

    assign rtc_flag   = flag_q;
    assign rtc_irq    = flag_q && ie_q;
    assign full_value = {rtc_count, rtc_presc};

    // ---------------- assertions ----------------
    AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!por_n)
        (counting && tick && full_value != '0) |=> (full_value == $past(full_value) - TOT_W'(1))); // R1

    AST_HALT_FROZEN: assert property (@(posedge clk) disable iff (!por_n)
        (state_q == ST_HALT && !reload_wr) |=> $stable(full_value)); // R3

    AST_REFILL_AT_ZERO: assert property (@(posedge clk) disable iff (!por_n)
        (counting && tick && full_value == '0) |=> (rtc_count == $past(reload_q) && rtc_presc == '1)); // R4

    AST_FLAG_ONLY_AT_WRAP: assert property (@(posedge clk) disable iff (!por_n)
        $rose(rtc_flag) |-> $past(counting && tick && full_value == '0)); // R4

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!por_n)
        (rtc_flag && !flag_clr) |=> rtc_flag); // R6
endmodule

// File: tb/sim_rtc_wake_timer.sv
module sim_rtc_wake_timer;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        cclk_tick = 1'b0, xtal_tick = 1'b0, xtal_is_cpu = 1'b0;
    logic        reload_wr = 1'b0;
    logic [15:0] reload_din = '0;
    logic        ctrl_wr = 1'b0, ctrl_run = 1'b0, ctrl_xsel = 1'b0, ctrl_irq_en = 1'b0;
    logic        flag_clr = 1'b0;
    logic [15:0] rtc_count;
    logic [6:0]  rtc_presc;
    logic        rtc_flag, rtc_irq, rtc_running;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_wake_timer u0 (
        .clk(clk), .por_n(por_n), .cclk_tick(cclk_tick), .xtal_tick(xtal_tick),
        .xtal_is_cpu(xtal_is_cpu), .reload_wr(reload_wr), .reload_din(reload_din),
        .ctrl_wr(ctrl_wr), .ctrl_run(ctrl_run), .ctrl_xsel(ctrl_xsel),
        .ctrl_irq_en(ctrl_irq_en), .flag_clr(flag_clr), .rtc_count(rtc_count),
        .rtc_presc(rtc_presc), .rtc_flag(rtc_flag), .rtc_irq(rtc_irq),
        .rtc_running(rtc_running)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [31:0] val23();
        return {9'd0, rtc_count, rtc_presc};
    endfunction

    task automatic tick(input bit cpu, input bit xt, input bit clr = 1'b0);
        @(negedge clk); cclk_tick = cpu; xtal_tick = xt; flag_clr = clr;
        @(negedge clk); cclk_tick = 1'b0; xtal_tick = 1'b0; flag_clr = 1'b0;
    endtask

    task automatic write_reload(input logic [15:0] v);
        @(negedge clk); reload_wr = 1'b1; reload_din = v;
        @(negedge clk); reload_wr = 1'b0;
    endtask

    task automatic write_ctrl(input bit run, input bit xs, input bit ie);
        @(negedge clk); ctrl_wr = 1'b1; ctrl_run = run; ctrl_xsel = xs; ctrl_irq_en = ie;
        @(negedge clk); ctrl_wr = 1'b0;
    endtask

    task automatic clear_flag();
        @(negedge clk); flag_clr = 1'b1;
        @(negedge clk); flag_clr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);

        // R8 defaults
        check("R8 count", rtc_count, 0);
        check("R8 presc", rtc_presc, 127);
        check("R8 flag", rtc_flag, 0);
        check("R8 irq", rtc_irq, 0);
        check("R8 running", rtc_running, 0);

        // R3 halted ignores ticks
        tick(1, 1);
        check("R3 halted value", val23(), 127);

        // R2 halted load
        write_reload(16'd5);
        check("R2 halted load count", rtc_count, 5);
        check("R2 halted load presc", rtc_presc, 127);

        // R1/R4 sweep over small reload values
        for (int r = 0; r < 4; r++) begin
            int v;
            v = r * 128 + 127;
            write_ctrl(0, 0, 0);
            clear_flag();
            write_reload(16'(r));
            write_ctrl(1, 0, 0);
            check("R3 running", rtc_running, 1);
            check("R3 no count before tick", val23(), v);
            for (int n = 1; n <= v; n++) begin
                tick(1, 0);
                check("R1 decrement", val23(), v - n);
                if (n == v) check("R4 flag before wrap", rtc_flag, 0);
            end
            tick(1, 0);
            check("R4 flag at wrap", rtc_flag, 1);
            check("R4 reload value", val23(), v);
            tick(1, 0);
            check("R6 flag sticky", rtc_flag, 1);
            check("R1 after wrap", val23(), v - 1);
        end

        // R7 gating
        check("R7 irq disabled", rtc_irq, 0);
        write_ctrl(1, 0, 1);
        check("R7 irq enabled", rtc_irq, 1);
        clear_flag();
        check("R6 clear", rtc_flag, 0);
        check("R7 irq after clear", rtc_irq, 0);

        // R2 running write only changes stored value
        write_ctrl(0, 0, 0);
        write_reload(16'd1);
        write_ctrl(1, 0, 0);
        tick(1, 0);
        write_reload(16'd0);
        check("R2 running write keeps count", val23(), 254);

        // R5 source selection
        write_ctrl(1, 1, 0);
        tick(1, 0);
        check("R5 xtal src ignores cpu", val23(), 254);
        tick(0, 1);
        check("R5 xtal src counts xtal", val23(), 253);
        xtal_is_cpu = 1'b1;
        tick(0, 1);
        check("R5 forced ignores xtal", val23(), 253);
        tick(1, 0);
        check("R5 forced counts cpu", val23(), 252);
        xtal_is_cpu = 1'b0;
        write_ctrl(1, 0, 0);
        tick(0, 1);
        check("R5 cpu src ignores xtal", val23(), 252);

        // R6 set wins over clear; new reload 0 is used at this wrap
        for (int n = 0; n < 252; n++) tick(1, 0);
        check("R6 at zero", val23(), 0);
        tick(1, 0, 1);
        check("R6 set wins", rtc_flag, 1);
        check("R2 stored reload used", val23(), 127);
        clear_flag();
        check("R6 cleared", rtc_flag, 0);

        // R3 stop freezes
        write_ctrl(0, 0, 1);
        check("R3 stopped", rtc_running, 0);
        tick(1, 0);
        check("R3 stop freezes", val23(), 127);

        // R8 power-on reset mid-run
        write_reload(16'd3);
        write_ctrl(1, 0, 1);
        for (int n = 0; n < 200; n++) tick(1, 0);
        @(negedge clk); por_n = 1'b0;
        @(negedge clk); por_n = 1'b1;
        @(negedge clk);
        check("R8 por count", rtc_count, 0);
        check("R8 por presc", rtc_presc, 127);
        check("R8 por running", rtc_running, 0);
        check("R8 por flag", rtc_flag, 0);
        write_ctrl(1, 0, 0);
        tick(1, 0);
        tick(1, 0);
        check("R8 por reload zero", val23(), 125);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule